// File: doc/BRIEF.md
# Register Operand Address Resolver

This block converts the register operand fields of an 8-bit processor's instructions into physical addresses for its register file. A field is either a full 8-bit register number or a 4-bit working-register number. Working-register numbers are moved into a 16-register page chosen by a register-pointer byte that the block holds. An 8-bit field whose upper nibble is hexadecimal E is treated as a working-register reference too, and is moved the same way.

Direct 8-bit numbers are allowed only in two windows: 0 to 127 and 240 to 255. Any other direct number raises the illegal flag. For a register-pair operand the block also gives the address of the second byte. The first address holds the high byte, and a pair must start on an even address. A set-pointer command loads the pointer byte. Only its upper nibble selects the page.

The address outputs are combinational from the operand inputs and the stored pointer. A pointer load takes effect in the cycle after the load strobe is sampled.

Top module: `regaddr_resolver`

## Requirements
- R1: After reset the pointer is zero, so working register n resolves to physical address n.
- R2: With `wreg_i` high, the physical address is the pointer's upper nibble followed by `field_i[3:0]`.
- R3: With `wreg_i` low and `field_i[7:4]` equal to hex E, the field resolves exactly as in R2, and it is never flagged for falling outside the direct windows.
- R4: A direct field in 0..127 or 240..255 passes through unchanged to `addr_o`, with `illegal_o` low (when not an odd pair).
- R5: A direct field in 128..223 raises `illegal_o`, with the field still passed to `addr_o`.
- R6: With `pair_i` high, `addr2_o` equals `addr_o` with bit 0 set. `addr_o` names the high byte.
- R7: With `pair_i` high, an odd resolved address raises `illegal_o`. This applies to direct, hex-E and 4-bit fields.
- R8: With `pair_i` low, `addr2_o` equals `addr_o`.
- R9: A load with `ptr_load_i` high takes effect from the next clock edge. Before that edge, resolution uses the old pointer. The lower nibble of `ptr_data_i` has no effect on any address.
- R10: With `wreg_i` high, `field_i[7:4]` has no effect on the outputs.
- R11: The control registers at 251, 252 and 253 are direct-window addresses: they pass through and are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_i | input | 8 | Operand field; only bits 3:0 are used when `wreg_i` is high |
| wreg_i | input | 1 | Field is a 4-bit working-register number |
| pair_i | input | 1 | Operand is a register pair |
| ptr_load_i | input | 1 | Load strobe for the pointer byte |
| ptr_data_i | input | 8 | Value to load into the pointer |
| addr_o | output | 8 | Resolved physical address (high byte for pairs) |
| addr2_o | output | 8 | Second-byte address for pairs |
| illegal_o | output | 1 | Address out of the direct windows, or odd pair |

## Verification
The pointer-load property assumes the load strobe is low while reset is held, because it compares against the sampled data of the previous cycle only when that cycle was out of reset. The stimulus respects this: it raises loads only after reset is released. It changes operand inputs only at falling edges, so every combinational property sees settled values at the rising edge. The hole and odd-pair properties assume `wreg_i` and `pair_i` are clean single-bit controls, and the bench drives them only to 0 or 1.

// File: rtl/regaddr_pkg.sv
package regaddr_pkg;

   // Kind of operand once it has been classified
   typedef enum logic [1:0] {
      KIND_DIRECT = 2'd0,
      KIND_WORK8  = 2'd1,
      KIND_WORK4  = 2'd2
   } opnd_kind_e;

   // Default geometry of the register address space
   localparam int unsigned DEF_ADDR_W     = 8;
   localparam int unsigned DEF_IDX_W      = 4;
   localparam int unsigned DEF_LOW_LAST   = 127;
   localparam int unsigned DEF_HIGH_FIRST = 240;
   localparam int unsigned DEF_WR_PREFIX  = 4'hE;

endpackage

// File: rtl/regaddr_ptr.sv
module regaddr_ptr #(
   parameter int unsigned PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [PAGE_W-1:0] page_i,
   output logic [PAGE_W-1:0] page_o
);

   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (load_i) begin
         page_q <= page_i;
      end
   end

   assign page_o = page_q;

endmodule

// File: rtl/regaddr_map.sv
module regaddr_map
   import regaddr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned WR_PREFIX = 4'hE
) (
   input  logic [ADDR_W-1:0]       field_i,
   input  logic                    wreg_i,
   input  logic [ADDR_W-IDX_W-1:0] page_i,
   output opnd_kind_e              kind_o,
   output logic [ADDR_W-1:0]       phys_o
);

   localparam int unsigned PAGE_W = ADDR_W - IDX_W;
   localparam logic [PAGE_W-1:0] PREFIX = PAGE_W'(WR_PREFIX);

   logic [IDX_W-1:0] idx;
   logic             is_prefixed;

   assign idx         = field_i[IDX_W-1:0];
   assign is_prefixed = (field_i[ADDR_W-1:IDX_W] == PREFIX);

   always_comb begin
      if (wreg_i) begin
         kind_o = KIND_WORK4;
      end else if (is_prefixed) begin
         kind_o = KIND_WORK8;
      end else begin
         kind_o = KIND_DIRECT;
      end
   end

   always_comb begin
      if (kind_o == KIND_DIRECT) begin
         phys_o = field_i;
      end else begin
         phys_o = {page_i, idx};
      end
   end

endmodule

// File: rtl/regaddr_legal.sv
module regaddr_legal
   import regaddr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned LOW_LAST   = 127,
   parameter int unsigned HIGH_FIRST = 240
) (
   input  opnd_kind_e        kind_i,
   input  logic [ADDR_W-1:0] phys_i,
   input  logic              pair_i,
   output logic              illegal_o
);

   logic in_window;
   logic odd_pair;

   generate
      if (HIGH_FIRST <= LOW_LAST + 1) begin : g_no_hole
         assign in_window = 1'b1;
      end else begin : g_hole
         localparam logic [ADDR_W-1:0] LO = ADDR_W'(LOW_LAST);
         localparam logic [ADDR_W-1:0] HI = ADDR_W'(HIGH_FIRST);
         assign in_window = (phys_i <= LO) || (phys_i >= HI);
      end
   endgenerate

   assign odd_pair  = pair_i && phys_i[0];
   assign illegal_o = odd_pair || ((kind_i == KIND_DIRECT) && !in_window);

endmodule

// File: rtl/regaddr_pair.sv
module regaddr_pair #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] first_i,
   input  logic              pair_i,
   output logic [ADDR_W-1:0] second_o
);

   always_comb begin
      second_o = first_i;
      if (pair_i) begin
         second_o[0] = 1'b1;
      end
   end

endmodule

// File: rtl/regaddr_resolver.sv
module regaddr_resolver
   import regaddr_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned IDX_W      = DEF_IDX_W,
   parameter int unsigned LOW_LAST   = DEF_LOW_LAST,
   parameter int unsigned HIGH_FIRST = DEF_HIGH_FIRST,
   parameter int unsigned WR_PREFIX  = DEF_WR_PREFIX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] field_i,
   input  logic              wreg_i,
   input  logic              pair_i,
   input  logic              ptr_load_i,
   input  logic [ADDR_W-1:0] ptr_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [ADDR_W-1:0] addr2_o,
   output logic              illegal_o
);

   localparam int unsigned PAGE_W   = ADDR_W - IDX_W;
   localparam int unsigned ADDR_MAX = (1 << ADDR_W) - 1;

   generate
      if (IDX_W == 0 || IDX_W >= ADDR_W) begin : g_bad_idx
         $error("IDX_W must lie strictly between 0 and ADDR_W");
      end
      if (HIGH_FIRST > ADDR_MAX || LOW_LAST > ADDR_MAX) begin : g_bad_window
         $error("window bounds exceed the address space");
      end
      if (WR_PREFIX >= (1 << PAGE_W)) begin : g_bad_prefix
         $error("WR_PREFIX does not fit the page field");
      end
   endgenerate

   logic [PAGE_W-1:0] page;
   opnd_kind_e        kind;
   logic [ADDR_W-1:0] phys;
   logic              unused_ptr_low;

   // Only the page nibble of the pointer byte selects anything
   assign unused_ptr_low = ^ptr_data_i[IDX_W-1:0];

   regaddr_ptr #(
      .PAGE_W (PAGE_W)
   ) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ptr_load_i),
      .page_i (ptr_data_i[ADDR_W-1:IDX_W]),
      .page_o (page)
   );

   regaddr_map #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .WR_PREFIX (WR_PREFIX)
   ) u_map (
      .field_i (field_i),
      .wreg_i  (wreg_i),
      .page_i  (page),
      .kind_o  (kind),
      .phys_o  (phys)
   );

   regaddr_legal #(
      .ADDR_W     (ADDR_W),
      .LOW_LAST   (LOW_LAST),
      .HIGH_FIRST (HIGH_FIRST)
   ) u_legal (
      .kind_i    (kind),
      .phys_i    (phys),
      .pair_i    (pair_i),
      .illegal_o (illegal_o)
   );

   regaddr_pair #(
      .ADDR_W (ADDR_W)
   ) u_pair (
      .first_i  (phys),
      .pair_i   (pair_i),
      .second_o (addr2_o)
   );

   assign addr_o = phys;

endmodule

// File: rtl/regaddr_resolver_chk.sv
module regaddr_resolver_chk #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned LOW_LAST   = 127,
   parameter int unsigned HIGH_FIRST = 240,
   parameter int unsigned WR_PREFIX  = 4'hE
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] field_i,
   input logic              wreg_i,
   input logic              pair_i,
   input logic              ptr_load_i,
   input logic [ADDR_W-1:0] ptr_data_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [ADDR_W-1:0] addr2_o,
   input logic              illegal_o
);

   logic direct_field;
   logic in_hole;

   assign direct_field = !wreg_i && (int'(field_i[ADDR_W-1:IDX_W]) != int'(WR_PREFIX));
   assign in_hole      = (int'(field_i) > int'(LOW_LAST)) && (int'(field_i) < int'(HIGH_FIRST));

   // R2
   work_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wreg_i |-> addr_o[IDX_W-1:0] == field_i[IDX_W-1:0]);

   // R3
   prefixed_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wreg_i && !direct_field && !pair_i) |-> !illegal_o);

   // R5
   hole_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (direct_field && in_hole) |-> (illegal_o && addr_o == field_i));

   // R6
   pair_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pair_i |-> (addr2_o[ADDR_W-1:1] == addr_o[ADDR_W-1:1] && addr2_o[0]));

   // R7
   odd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_i && addr_o[0]) |-> illegal_o);

   // R8
   single_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_i |-> addr2_o == addr_o);

   // R9
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ptr_load_i) && wreg_i)
      |-> addr_o[ADDR_W-1:IDX_W] == $past(ptr_data_i[ADDR_W-1:IDX_W]));

endmodule

bind regaddr_resolver regaddr_resolver_chk #(
   .ADDR_W     (ADDR_W),
   .IDX_W      (IDX_W),
   .LOW_LAST   (LOW_LAST),
   .HIGH_FIRST (HIGH_FIRST),
   .WR_PREFIX  (WR_PREFIX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .field_i    (field_i),
   .wreg_i     (wreg_i),
   .pair_i     (pair_i),
   .ptr_load_i (ptr_load_i),
   .ptr_data_i (ptr_data_i),
   .addr_o     (addr_o),
   .addr2_o    (addr2_o),
   .illegal_o  (illegal_o)
);

// File: tb/test_regaddr_resolver.sv
`timescale 1ns/1ps
module test_regaddr_resolver;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] field_i = '0;
   logic       wreg_i = 1'b0;
   logic       pair_i = 1'b0;
   logic       ptr_load_i = 1'b0;
   logic [7:0] ptr_data_i = '0;
   logic [7:0] addr_o;
   logic [7:0] addr2_o;
   logic       illegal_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   regaddr_resolver i_regaddr_resolver (
      .clk        (clk),
      .rst_n      (rst_n),
      .field_i    (field_i),
      .wreg_i     (wreg_i),
      .pair_i     (pair_i),
      .ptr_load_i (ptr_load_i),
      .ptr_data_i (ptr_data_i),
      .addr_o     (addr_o),
      .addr2_o    (addr2_o),
      .illegal_o  (illegal_o)
   );

   // {req[3:0], wreg, pair, field[7:0], addr[7:0], addr2[7:0], illegal}
   // Expected values assume the pointer holds 0x37 (page 3)
   localparam int NV = 22;
   localparam logic [30:0] VEC [NV] = '{
      {4'd2,  1'b1, 1'b0, 8'h05, 8'h35, 8'h35, 1'b0}, // R2
      {4'd10, 1'b1, 1'b0, 8'hA9, 8'h39, 8'h39, 1'b0}, // R10 upper nibble ignored
      {4'd6,  1'b1, 1'b1, 8'h04, 8'h34, 8'h35, 1'b0}, // R6 working pair
      {4'd7,  1'b1, 1'b1, 8'h07, 8'h37, 8'h37, 1'b1}, // R7 odd working pair
      {4'd3,  1'b0, 1'b0, 8'hE2, 8'h32, 8'h32, 1'b0}, // R3
      {4'd3,  1'b0, 1'b0, 8'hEF, 8'h3F, 8'h3F, 1'b0}, // R3
      {4'd4,  1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0}, // R4
      {4'd4,  1'b0, 1'b0, 8'h7F, 8'h7F, 8'h7F, 1'b0}, // R4 low window top
      {4'd4,  1'b0, 1'b0, 8'hF0, 8'hF0, 8'hF0, 1'b0}, // R4 high window base
      {4'd11, 1'b0, 1'b0, 8'hFB, 8'hFB, 8'hFB, 1'b0}, // R11
      {4'd11, 1'b0, 1'b0, 8'hFC, 8'hFC, 8'hFC, 1'b0}, // R11
      {4'd11, 1'b0, 1'b0, 8'hFD, 8'hFD, 8'hFD, 1'b0}, // R11
      {4'd5,  1'b0, 1'b0, 8'h80, 8'h80, 8'h80, 1'b1}, // R5 hole base
      {4'd5,  1'b0, 1'b0, 8'hDF, 8'hDF, 8'hDF, 1'b1}, // R5 hole top
      {4'd5,  1'b0, 1'b0, 8'hA5, 8'hA5, 8'hA5, 1'b1}, // R5
      {4'd6,  1'b0, 1'b1, 8'h7E, 8'h7E, 8'h7F, 1'b0}, // R6
      {4'd6,  1'b0, 1'b1, 8'hF4, 8'hF4, 8'hF5, 1'b0}, // R6
      {4'd7,  1'b0, 1'b1, 8'h41, 8'h41, 8'h41, 1'b1}, // R7
      {4'd6,  1'b0, 1'b1, 8'hE4, 8'h34, 8'h35, 1'b0}, // R6 prefixed pair
      {4'd7,  1'b0, 1'b1, 8'hE3, 8'h33, 8'h33, 1'b1}, // R7 prefixed odd pair
      {4'd7,  1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b1}, // R7
      {4'd5,  1'b0, 1'b1, 8'h80, 8'h80, 8'h81, 1'b1}  // R5 pair in hole
   };

   task automatic check(input string tag, input logic [7:0] ea,
                        input logic [7:0] ea2, input logic eill);
      n_checks++;
      if (addr_o !== ea || addr2_o !== ea2 || illegal_o !== eill) begin
         n_fail++;
         $display("FAIL %s: got addr=%h addr2=%h ill=%b expected addr=%h addr2=%h ill=%b",
                  tag, addr_o, addr2_o, illegal_o, ea, ea2, eill);
      end
   endtask

   task automatic apply(input logic w, input logic p, input logic [7:0] f);
      @(negedge clk);
      wreg_i  = w;
      pair_i  = p;
      field_i = f;
      #1;
   endtask

   task automatic load_ptr(input logic [7:0] v);
      @(negedge clk);
      ptr_load_i = 1'b1;
      ptr_data_i = v;
      @(negedge clk);
      ptr_load_i = 1'b0;
      ptr_data_i = 8'h00;
   endtask

   initial begin
      #150000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: pointer zero after reset
      apply(1'b1, 1'b0, 8'h0A);
      check("R1", 8'h0A, 8'h0A, 1'b0);
      apply(1'b0, 1'b0, 8'hE6);
      check("R1", 8'h06, 8'h06, 1'b0);

      // R9: load not visible before the edge, visible after
      apply(1'b1, 1'b0, 8'h05);
      ptr_load_i = 1'b1;
      ptr_data_i = 8'h37;
      #1;
      check("R9", 8'h05, 8'h05, 1'b0);
      @(negedge clk);
      ptr_load_i = 1'b0;
      ptr_data_i = 8'h00;
      #1;
      check("R9", 8'h35, 8'h35, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [30:0] v;
         string tag;
         v = VEC[i];
         apply(v[26], v[25], v[24:17]);
         tag = $sformatf("R%0d row %0d", v[30:27], i);
         check(tag, v[16:9], v[8:1], v[0]);
      end

      // R9: lower nibble of loaded value has no effect
      load_ptr(8'hF0);
      apply(1'b1, 1'b0, 8'h0C);
      check("R9", 8'hFC, 8'hFC, 1'b0);
      load_ptr(8'hFF);
      apply(1'b1, 1'b0, 8'h0C);
      check("R9", 8'hFC, 8'hFC, 1'b0);

      // R3: prefixed field relocated into the hole page stays legal
      load_ptr(8'h90);
      apply(1'b0, 1'b0, 8'hE1);
      check("R3", 8'h91, 8'h91, 1'b0);
      // R5: same physical value written directly is flagged
      apply(1'b0, 1'b0, 8'h91);
      check("R5", 8'h91, 8'h91, 1'b1);

      // R1: reset mid-run clears the pointer
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      apply(1'b1, 1'b1, 8'h02);
      check("R1", 8'h02, 8'h03, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule